// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a two-channel serial audio stream made of a bit clock, a frame clock and one data line, and turns it into pairs of 18-bit signed samples, left and right, on the system clock. A 2-bit format input picks one of four framings: 16-bit or 18-bit words aligned to the end of each channel half, 18-bit words aligned to its start, or the I2S framing, where the word starts one bit clock late. All three serial inputs are oversampled by the system clock through synchronisers. Data is taken at each detected rising edge of the bit clock. Words always arrive MSB first in two's complement, and 16-bit words are widened by appending two zero LSBs so that full scale is the same in every format.

A pair leaves the block only when a complete left half and the right half that follows it have both been received. If a channel half has fewer bit clocks than its format needs, the block raises a one-cycle error pulse and drops that frame. Samples leave on a valid/ready interface. Once `smp_valid` is high, `smp_left` and `smp_right` stay unchanged until a cycle in which `smp_ready` is high. A pair that finishes while the output still holds an unaccepted pair is dropped, so a consumer that stalls longer than one frame loses frames, not order. When `pd_n` is low the block is cleared and the sample outputs read zero.

Top module: `ser_audio_rx`

## Requirements
- R1: With `fmt_sel`=00, each channel word is the last 16 bits before the frame-clock edge that ends the half. It is output as those 16 bits followed by two zero LSBs. Earlier bit slots in the half have no effect.
- R2: With `fmt_sel`=01, each channel word is the last 18 bits before the frame-clock edge that ends the half. Earlier bit slots have no effect.
- R3: With `fmt_sel`=10, each channel word is the 18 bits that start at the first bit clock after the frame-clock edge. Bits after the 18th slot of the half have no effect.
- R4: With `fmt_sel`=11 (I2S), the MSB arrives one bit clock after the frame-clock edge, and frame clock low selects the left channel. A half of exactly 16 bit clocks carries a 16-bit word, whose last bit falls in the first slot of the next half. A half of 18 or more bit clocks carries an 18-bit word.
- R5: With `fmt_sel` 00, 01 or 10, frame clock high selects the left channel and low selects the right.
- R6: A half shorter than its format needs raises `fmt_err` for one clock and discards that frame's pair. The minimums are 16 bit clocks for 00, 18 for 01 and 10, and exactly 16 or at least 18 for 11.
- R7: A pair is emitted only for a left half followed by a right half, both complete. The partial half in progress after reset or power-down is never emitted.
- R8: While `smp_valid` is high and `smp_ready` is low, the output pair stays unchanged. A pair that completes during that time is discarded.
- R9: While `pd_n` is low, `smp_valid` is low and both sample outputs are zero. After reset the outputs are likewise zero and invalid.
- R10: Samples keep their two's complement sign: a word with MSB set appears as a negative 18-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down, synchronous clear |
| fmt_sel | input | 2 | Framing select: 00, 01, 10, 11 as in R1 to R4 |
| bit_clk | input | 1 | Serial bit clock, oversampled |
| frame_clk | input | 1 | Channel-select frame clock |
| ser_data | input | 1 | Serial data, MSB first |
| smp_valid | output | 1 | Sample pair available |
| smp_ready | input | 1 | Consumer accepts the pair |
| smp_left | output | 18 | Left sample, signed |
| smp_right | output | 18 | Right sample, signed |
| fmt_err | output | 1 | One-cycle pulse on a short channel half |

## Verification
The hardest case to reach from the ports is I2S at 32 bit clocks per frame, and at exactly 36. There the last bit of a word falls in the first slot of the next half, so the decision on the right word waits until the frame after it has begun. The bench builds each half's bit stream as if it were start-aligned, then shifts it by one slot and carries the leftover bit into the next half. It also sends a trailing half after every burst, so the final right word can complete. Short halves are produced by giving one channel fewer slots than its partner, which lets the bench show that a good frame ahead of the short one still comes out.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_LSB16 = 2'b00,
    FMT_LSB18 = 2'b01,
    FMT_MSB18 = 2'b10,
    FMT_I2S   = 2'b11
  } srx_fmt_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_one
      logic [W-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st <= '0;
        else if (!clr_n) st <= '0;
        else             st <= d;
      end
      assign q = st;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st <= '0;
        else if (!clr_n) st <= '0;
        else             st <= {st[STAGES-2:0], d};
      end
      assign q = st[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/srx_frame_dec.sv
module srx_frame_dec
  import srx_pkg::*;
#(
  parameter int DW = 18,
  parameter int NW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  srx_fmt_e      fmt,
  input  logic          bclk_s,
  input  logic          fclk_s,
  input  logic          sd_s,
  output logic          pair_push,
  output logic [DW-1:0] pair_l,
  output logic [DW-1:0] pair_r,
  output logic          err_pulse
);

  localparam int PAD = DW - NW;
  localparam logic [CW-1:0] CMAX    = {CW{1'b1}};
  localparam logic [CW-1:0] C_SHORT = CW'(NW);
  localparam logic [CW-1:0] C_LONG  = CW'(DW);
  localparam logic [CW-1:0] C_LAST  = CW'(DW - 1);

  logic          bclk_q;
  logic [1:0]    prime;
  logic          fr_prev, eff_q, started, got, lpend;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, hw, lw;

  logic          rise, eff, edge_ev, msb_hit, half_ok;
  logic [DW-1:0] short_word, half_word;

  assign rise       = bclk_s & ~bclk_q;
  // I2S uses the frame clock delayed by one slot and inverted.
  assign eff        = (fmt == FMT_I2S) ? ~fr_prev : fclk_s;
  assign edge_ev    = rise && (prime == 2'd2) && (eff != eff_q);
  assign msb_hit    = rise && (prime == 2'd2) && !edge_ev && fmt[1] && (cnt == C_LAST);
  assign short_word = {shreg[NW-1:0], {PAD{1'b0}}};

  always_comb begin
    half_ok   = 1'b0;
    half_word = shreg;
    unique case (fmt)
      FMT_LSB16: begin half_ok = (cnt >= C_SHORT); half_word = short_word; end
      FMT_LSB18: begin half_ok = (cnt >= C_LONG);  half_word = shreg;      end
      FMT_MSB18: begin half_ok = got;              half_word = hw;         end
      FMT_I2S:   begin
        half_ok   = got || (cnt == C_SHORT);
        half_word = got ? hw : short_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !clr_n) begin
      bclk_q <= 1'b0; prime <= '0; fr_prev <= 1'b0; eff_q <= 1'b0;
      started <= 1'b0; got <= 1'b0; lpend <= 1'b0; cnt <= '0;
      shreg <= '0; hw <= '0; lw <= '0;
      pair_push <= 1'b0; pair_l <= '0; pair_r <= '0; err_pulse <= 1'b0;
    end else begin
      bclk_q    <= bclk_s;
      pair_push <= 1'b0;
      err_pulse <= 1'b0;
      if (rise) begin
        shreg   <= {shreg[DW-2:0], sd_s};
        fr_prev <= fclk_s;
        eff_q   <= eff;
        if (prime != 2'd2) begin
          prime <= prime + 2'd1;
        end else if (edge_ev) begin
          cnt     <= CW'(1);
          got     <= 1'b0;
          started <= 1'b1;
          if (started) begin
            if (!half_ok) begin
              err_pulse <= 1'b1;
              lpend     <= 1'b0;
            end else if (eff_q) begin
              lw    <= half_word;
              lpend <= 1'b1;
            end else if (lpend) begin
              pair_push <= 1'b1;
              pair_l    <= lw;
              pair_r    <= half_word;
              lpend     <= 1'b0;
            end
          end
        end else begin
          if (cnt != CMAX) cnt <= cnt + CW'(1);
          if (msb_hit) begin
            hw  <= {shreg[DW-2:0], sd_s};
            got <= 1'b1;
          end
        end
      end
    end
  end

  // R7: pairs are produced only on a detected bit-clock rising edge
  p_push_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_push |-> $past(rise));

  // R6: the error pulse also follows only a bit-clock rising edge
  p_err_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rise));

endmodule

// File: rtl/srx_out_reg.sv
module srx_out_reg #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          push,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);

  logic can_load;
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !clr_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else if (push && can_load) begin
      out_valid <= 1'b1;
      out_l     <= in_l;
      out_r     <= in_r;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled pair is held unchanged
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && clr_n) |=> (out_valid && $stable(out_l) && $stable(out_r)));

  // R8: valid only rises because a pair was pushed
  p_rise_needs_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(push));

  // R9: power-down empties the output and zeroes the data
  p_pd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!out_valid && out_l == '0 && out_r == '0));

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import srx_pkg::*;
#(
  parameter int DW          = 18,
  parameter int NW          = 16,
  parameter int CW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic [1:0]    fmt_sel,
  input  logic          bit_clk,
  input  logic          frame_clk,
  input  logic          ser_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_left,
  output logic [DW-1:0] smp_right,
  output logic          fmt_err
);

  logic [2:0]    sync_q;
  logic          push;
  logic [DW-1:0] pl, pr;

  srx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (pd_n),
    .d     ({bit_clk, frame_clk, ser_data}),
    .q     (sync_q)
  );

  srx_frame_dec #(.DW(DW), .NW(NW), .CW(CW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (pd_n),
    .fmt       (srx_fmt_e'(fmt_sel)),
    .bclk_s    (sync_q[2]),
    .fclk_s    (sync_q[1]),
    .sd_s      (sync_q[0]),
    .pair_push (push),
    .pair_l    (pl),
    .pair_r    (pr),
    .err_pulse (fmt_err)
  );

  srx_out_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (pd_n),
    .push      (push),
    .in_l      (pl),
    .in_r      (pr),
    .out_valid (smp_valid),
    .out_ready (smp_ready),
    .out_l     (smp_left),
    .out_r     (smp_right)
  );

endmodule

// File: tb/ser_audio_rx_tb_top.sv
`timescale 1ns/1ps
module ser_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bit_clk = 1'b1;
  logic        frame_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [17:0] smp_left, smp_right;
  logic        fmt_err;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  logic pend = 1'b0;
  logic [35:0] got_q[$];
  logic [35:0] exp_q[$];

  always #2 clk = ~clk;

  ser_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .fmt_sel(fmt_sel),
    .bit_clk(bit_clk), .frame_clk(frame_clk), .ser_data(ser_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .fmt_err(fmt_err)
  );

  always @(negedge clk) begin
    if (smp_valid && smp_ready) got_q.push_back({smp_left, smp_right});
    if (fmt_err) err_seen++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic junk(input int s);
    return 1'(((s * 5) + 1) >> 1);
  endfunction

  function automatic logic ebit(input int s, input int h, input logic [17:0] w, input int wl);
    if (fmt_sel == 2'b00 || fmt_sel == 2'b01) begin
      if (s >= h - wl) return w[17 - (s - (h - wl))];
      return junk(s);
    end
    if (s < wl) return w[17 - s];
    return junk(s);
  endfunction

  task automatic slot(input logic lvl, input logic b);
    frame_clk = lvl;
    ser_data  = b;
    bit_clk   = 1'b0;
    #16;
    bit_clk   = 1'b1;
    #16;
  endtask

  task automatic send_half(input logic left, input int h, input logic [17:0] w, input int wl);
    logic lvl;
    lvl = (fmt_sel == 2'b11) ? ~left : left;
    for (int s = 0; s < h; s++) begin
      if (fmt_sel == 2'b11) slot(lvl, (s == 0) ? pend : ebit(s - 1, h, w, wl));
      else                  slot(lvl, ebit(s, h, w, wl));
    end
    if (fmt_sel == 2'b11) pend = ebit(h - 1, h, w, wl);
  endtask

  function automatic logic [17:0] xw(input logic [17:0] w, input int wl);
    return (wl == 16) ? {w[17:2], 2'b00} : w;
  endfunction

  task automatic send_frame(input int h, input logic [17:0] l, input logic [17:0] r, input int wl);
    send_half(1'b1, h, l, wl);
    send_half(1'b0, h, r, wl);
    exp_q.push_back({xw(l, wl), xw(r, wl)});
  endtask

  task automatic restart(input logic [1:0] m);
    @(posedge clk); #1;
    pd_n = 1'b0;
    fmt_sel = m;
    pend = 1'b0;
    repeat (4) @(posedge clk);
    #1 pd_n = 1'b1;
    got_q.delete();
    exp_q.delete();
    err_seen = 0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic cmp_pairs(input string req);
    check({req, " pair count"}, 64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check({req, " pair data"}, 64'(got_q[i]), 64'(exp_q[i]));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 reset valid", 64'(smp_valid), 64'd0);
    check("R9 reset left",  64'(smp_left),  64'd0);
    check("R9 reset right", 64'(smp_right), 64'd0);
    check("R6 reset err",   64'(fmt_err),   64'd0);
  endtask

  task automatic t_lsb16();
    restart(2'b00);
    send_half(1'b0, 32, 18'h0, 16);
    send_frame(32, 18'h1234C, 18'h2ABCD, 16);
    send_frame(16, 18'h3FFFC, 18'h00004, 16);
    send_half(1'b1, 32, 18'h0, 16);
    settle();
    cmp_pairs("R1 R5 lsb16");
    check("R1 no err", 64'(err_seen), 64'd0);
  endtask

  task automatic t_lsb18();
    restart(2'b01);
    send_half(1'b0, 18, 18'h0, 18);
    send_frame(18, 18'h20001, 18'h1FFFF, 18);
    send_frame(24, 18'h0A5A5, 18'h35A5B, 18);
    send_half(1'b1, 18, 18'h0, 18);
    settle();
    cmp_pairs("R2 R5 R10 lsb18");
    if (got_q.size() > 0) check("R10 sign", 64'(got_q[0][35]), 64'd1);
  endtask

  task automatic t_msb18();
    restart(2'b10);
    send_half(1'b0, 32, 18'h0, 18);
    send_frame(32, 18'h2F00F, 18'h10FF1, 18);
    send_frame(18, 18'h00001, 18'h3FFFF, 18);
    send_half(1'b1, 32, 18'h0, 18);
    settle();
    cmp_pairs("R3 R5 msb18");
  endtask

  task automatic t_i2s();
    restart(2'b11);
    send_half(1'b0, 16, 18'h0, 16);
    send_frame(16, 18'h2468C, 18'h13578, 16);
    send_half(1'b1, 16, 18'h0, 16);
    settle();
    cmp_pairs("R4 i2s 32fs");
    restart(2'b11);
    send_half(1'b0, 18, 18'h0, 18);
    send_frame(18, 18'h30003, 18'h0C00C, 18);
    send_frame(32, 18'h2AAAA, 18'h15555, 18);
    send_half(1'b1, 18, 18'h0, 18);
    settle();
    cmp_pairs("R4 R10 i2s 36fs and 64fs");
    check("R4 no err", 64'(err_seen), 64'd0);
  endtask

  task automatic t_short();
    restart(2'b01);
    send_half(1'b0, 18, 18'h0, 18);
    send_frame(18, 18'h11111, 18'h22222, 18);
    send_half(1'b1, 18, 18'h33333, 18);
    send_half(1'b0, 16, 18'h04444, 16);
    send_half(1'b1, 18, 18'h0, 18);
    settle();
    cmp_pairs("R6 R7 short right half");
    check("R6 err count lsb18", 64'(err_seen), 64'd1);
    restart(2'b11);
    send_half(1'b0, 17, 18'h0, 18);
    send_half(1'b1, 17, 18'h12345, 18);
    send_half(1'b0, 17, 18'h23456, 18);
    send_half(1'b1, 17, 18'h0, 18);
    settle();
    check("R6 i2s 17 slots no pair", 64'(got_q.size()), 64'd0);
    check("R6 i2s 17 slots err", 64'(err_seen), 64'd2);
  endtask

  task automatic t_partial();
    restart(2'b00);
    send_half(1'b1, 32, 18'h3C3C0, 16);
    send_half(1'b0, 32, 18'h0F0F0, 16);
    send_frame(32, 18'h01230, 18'h04560, 16);
    send_half(1'b1, 32, 18'h0, 16);
    settle();
    cmp_pairs("R7 leading half not paired");
  endtask

  task automatic t_backpressure();
    logic [35:0] first;
    restart(2'b00);
    smp_ready = 1'b0;
    send_half(1'b0, 32, 18'h0, 16);
    send_frame(32, 18'h11114, 18'h22228, 16);
    send_frame(32, 18'h3333C, 18'h04440, 16);
    send_half(1'b1, 32, 18'h0, 16);
    settle();
    first = exp_q[0];
    check("R8 stalled valid", 64'(smp_valid), 64'd1);
    check("R8 stalled data", 64'({smp_left, smp_right}), 64'(first));
    repeat (50) @(negedge clk);
    check("R8 still stable", 64'({smp_left, smp_right}), 64'(first));
    @(posedge clk); #1 smp_ready = 1'b1;
    settle();
    check("R8 one transfer", 64'(got_q.size()), 64'd1);
    if (got_q.size() > 0) check("R8 transfer data", 64'(got_q[0]), 64'(first));
    check("R8 second dropped", 64'(smp_valid), 64'd0);
  endtask

  task automatic t_powerdown();
    restart(2'b00);
    smp_ready = 1'b0;
    send_half(1'b0, 32, 18'h0, 16);
    send_frame(32, 18'h1ABC4, 18'h2DEF8, 16);
    send_half(1'b1, 32, 18'h0, 16);
    settle();
    check("R9 held before pd", 64'(smp_valid), 64'd1);
    @(posedge clk); #1 pd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 pd valid", 64'(smp_valid), 64'd0);
    check("R9 pd left",  64'(smp_left),  64'd0);
    check("R9 pd right", 64'(smp_right), 64'd0);
    send_half(1'b0, 32, 18'h0, 16);
    send_half(1'b1, 32, 18'h0, 16);
    check("R9 no output in pd", 64'(smp_valid), 64'd0);
    @(posedge clk); #1 pd_n = 1'b1; smp_ready = 1'b1;
    got_q.delete();
    exp_q.delete();
    send_half(1'b0, 32, 18'h0, 16);
    send_frame(32, 18'h05550, 18'h3AAA8, 16);
    send_half(1'b1, 32, 18'h0, 16);
    settle();
    cmp_pairs("R9 after pd release");
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_lsb16();
    t_lsb18();
    t_msb18();
    t_i2s();
    t_short();
    t_partial();
    t_backpressure();
    t_powerdown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule